// File: doc/BRIEF.md
# Video Interrupt Status and Enable Register

This block merges the interrupt sources of a video controller into one active-high request line. Two local events feed it. The first is a scan-line event, which is raised at the start of a displayed row when that row's line-control value asks for it. The second is a once-per-second tick. Each event latches a status bit. Each source also has an enable bit, and the block keeps a summary bit that is set when an enabled source has a pending status.

A processor sees all of this as one 8-bit register and reaches it through three plain operations:

- a read returns the whole register;
- a control write loads the two enable bits;
- a clear write acknowledges pending status bits by writing zeros into their positions.

A second group of interrupt sources enters as a mask vector and a state vector. If any bit is set in both vectors, the request line is asserted. These sources have no effect on the register.

Status bits latch even while their source is disabled, so software can poll them without taking an interrupt. The row timing, the one-second timebase and the raster are generated elsewhere. They arrive here as single-cycle pulses, together with the current row's line-control byte.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq` is low.
- R2: A `sec_tick` pulse sets status bit 6 one cycle later, whatever the value of enable bit 2.
- R3: A `row_start` pulse sets status bit 5 one cycle later only when bit 6 of `row_ctrl` is 1. When that bit is 0, the pulse leaves the register unchanged.
- R4: On a clear write (`wr_clr`), a 0 in `wdata` bit 5 or bit 6 clears that status bit, and a 1 leaves it as it was. The other bit positions of `wdata` have no effect on the register.
- R5: A control write (`wr_ctrl`) loads register bits 1 and 2 from `wdata` bits 1 and 2. It leaves every other bit of the register unchanged. Without a control write, bits 1 and 2 keep their values.
- R6: In the cycle after any event or write, bit 7 equals (bit 5 AND bit 1) OR (bit 6 AND bit 2). Each status bit is paired with the enable bit four positions below it.
- R7: Bits 0, 3 and 4 always read 0, whatever is written or raised.
- R8: When a source event and a clear write that clears the same status bit arrive in the same cycle, the status bit ends up set.
- R9: `irq` is asserted exactly when register bit 7 is 1 or when (`sec_mask` AND `sec_state`) is non-zero. The secondary term acts in the same cycle.
- R10: `rdata` always presents the full current register, bit 7 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_start | input | 1 | Single-cycle pulse at the start of a displayed row |
| row_ctrl | input | 8 | Line-control byte of the current row; bit 6 requests the scan-line event |
| sec_tick | input | 1 | Single-cycle once-per-second pulse |
| wr_ctrl | input | 1 | Control write strobe (loads the enables) |
| wr_clr | input | 1 | Clear write strobe (zeros acknowledge status bits) |
| wdata | input | 8 | Write data for both write operations |
| rdata | output | 8 | Current register value |
| sec_mask | input | SEC_W | Mask of the secondary interrupt group |
| sec_state | input | SEC_W | Pending state of the secondary interrupt group |
| irq | output | 1 | Combined active-high interrupt request |

## Verification
A wrong status or enable bit shows up on `rdata` in the very next cycle after the event or write that produced it. It shows up on `irq` at the same time, through the summary bit. A status bit that fails to clear, or an enable bit that changes when it should not, appears at once on the read port. It then stays visible until a later write corrects it. The bench therefore compares `rdata` and `irq` after every single operation. It sweeps all 256 write values against a range of prior register states. This exposes any stray bit, any lost enable and any wrong pairing of status and enable bits within one cycle.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_SUM    = 7;
  localparam int unsigned B_SEC    = 6;
  localparam int unsigned B_LINE   = 5;
  localparam int unsigned B_SEC_EN = 2;
  localparam int unsigned B_LN_EN  = 1;
  localparam int unsigned EN_GAP   = 4;
  localparam int unsigned NSRC     = 2;
  localparam int unsigned LC_REQ   = 6;
  localparam logic [REG_W-1:0] RSV_MASK = 8'b0001_1001;
  typedef logic [REG_W-1:0] irq_reg_t;
endpackage

// File: rtl/vid_irq_evgate.sv
module vid_irq_evgate
  import vid_irq_pkg::*;
#(
  parameter int unsigned LC_W = 8
) (
  input  logic            row_start,
  input  logic [LC_W-1:0] row_ctrl,
  output logic            line_ev
);
  assign line_ev = row_start & row_ctrl[LC_REQ];
endmodule

// File: rtl/vid_irq_status.sv
module vid_irq_status
  import vid_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_ev,
  input  logic     tick_ev,
  input  logic     wr_ctrl,
  input  logic     wr_clr,
  input  irq_reg_t wdata,
  output irq_reg_t stat
);
  localparam int unsigned SRC_POS [NSRC] = '{B_LINE, B_SEC};

  irq_reg_t stat_q, pre, nxt;
  logic [NSRC-1:0] hit;

  always_comb begin
    pre = stat_q;
    if (wr_clr) begin
      pre[B_LINE] = pre[B_LINE] & wdata[B_LINE];
      pre[B_SEC]  = pre[B_SEC]  & wdata[B_SEC];
    end
    if (wr_ctrl) begin
      pre[B_LN_EN]  = wdata[B_LN_EN];
      pre[B_SEC_EN] = wdata[B_SEC_EN];
    end
    if (tick_ev) pre[B_SEC]  = 1'b1;
    if (line_ev) pre[B_LINE] = 1'b1;
    pre = pre & ~RSV_MASK;
    pre[B_SUM] = 1'b0;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = pre[SRC_POS[g]] & pre[SRC_POS[g] - EN_GAP];
  end

  always_comb begin
    nxt = pre;
    nxt[B_SUM] = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= nxt;
  end

  assign stat = stat_q;

  AST_SUM_CONSIST: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[B_SUM] == ((stat_q[B_LINE] & stat_q[B_LN_EN]) | (stat_q[B_SEC] & stat_q[B_SEC_EN]))); // R6
  AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ev |=> stat_q[B_SEC]); // R2
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wdata[B_LINE] && !line_ev) |=> !stat_q[B_LINE]); // R4
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (stat_q[B_SEC_EN:B_LN_EN] == $past(wdata[B_SEC_EN:B_LN_EN]))); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(stat_q[B_SEC_EN:B_LN_EN])); // R5
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ev && wr_clr) |=> stat_q[B_LINE]); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & RSV_MASK) == '0); // R7
endmodule

// File: rtl/vid_irq_merge.sv
module vid_irq_merge #(
  parameter int unsigned SEC_W = 8
) (
  input  logic             sum_bit,
  input  logic [SEC_W-1:0] sec_mask,
  input  logic [SEC_W-1:0] sec_state,
  output logic             irq
);
  logic [SEC_W-1:0] sec_hit;
  assign sec_hit = sec_mask & sec_state;
  assign irq     = sum_bit | (|sec_hit);
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl
  import vid_irq_pkg::*;
#(
  parameter int unsigned SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_start,
  input  logic [7:0]       row_ctrl,
  input  logic             sec_tick,
  input  logic             wr_ctrl,
  input  logic             wr_clr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [SEC_W-1:0] sec_mask,
  input  logic [SEC_W-1:0] sec_state,
  output logic             irq
);
  logic     line_ev;
  irq_reg_t stat;

  vid_irq_evgate #(.LC_W(8)) u_gate (
    .row_start(row_start), .row_ctrl(row_ctrl), .line_ev(line_ev)
  );

  vid_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .line_ev(line_ev), .tick_ev(sec_tick),
    .wr_ctrl(wr_ctrl), .wr_clr(wr_clr), .wdata(wdata), .stat(stat)
  );

  vid_irq_merge #(.SEC_W(SEC_W)) u_merge (
    .sum_bit(stat[B_SUM]), .sec_mask(sec_mask), .sec_state(sec_state), .irq(irq)
  );

  assign rdata = stat;

  AST_IRQ_FROM_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[B_SUM] |-> irq); // R9
endmodule

// File: tb/vid_irq_ctrl_tb_top.sv
module vid_irq_ctrl_tb_top;
  localparam int SEC_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_start = 1'b0, sec_tick = 1'b0, wr_ctrl = 1'b0, wr_clr = 1'b0;
  logic [7:0] row_ctrl = '0, wdata = '0, rdata;
  logic [SEC_W-1:0] sec_mask = '0, sec_state = '0;
  logic irq;

  int checks = 0, failures = 0;
  logic [7:0] expv = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vid_irq_ctrl #(.SEC_W(SEC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_ctrl(row_ctrl),
    .sec_tick(sec_tick), .wr_ctrl(wr_ctrl), .wr_clr(wr_clr), .wdata(wdata),
    .rdata(rdata), .sec_mask(sec_mask), .sec_state(sec_state), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] s, input logic tk, input logic rs,
                                       input logic [7:0] rc, input logic wc, input logic wl,
                                       input logic [7:0] d);
    logic [7:0] m = s;
    if (wl) begin m[5] = m[5] & d[5]; m[6] = m[6] & d[6]; end
    if (wc) begin m[1] = d[1]; m[2] = d[2]; end
    if (tk) m[6] = 1'b1;
    if (rs && rc[6]) m[5] = 1'b1;
    m[0] = 1'b0; m[3] = 1'b0; m[4] = 1'b0;
    m[7] = (m[5] & m[1]) | (m[6] & m[2]);
    return m;
  endfunction

  task automatic op(input string tag, input logic tk, input logic rs, input logic [7:0] rc,
                    input logic wc, input logic wl, input logic [7:0] d);
    @(negedge clk);
    sec_tick = tk; row_start = rs; row_ctrl = rc; wr_ctrl = wc; wr_clr = wl; wdata = d;
    @(posedge clk);
    #2;
    sec_tick = 0; row_start = 0; wr_ctrl = 0; wr_clr = 0;
    expv = model(expv, tk, rs, rc, wc, wl, d);
    chk(tag, rdata, expv);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, expv[7]});
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;

    op("R2 tick while disabled", 1, 0, 8'h00, 0, 0, 8'h00);
    op("R3 row without request bit", 0, 1, 8'hBF, 0, 0, 8'h00);
    op("R3 row with request bit", 0, 1, 8'h40, 0, 0, 8'h00);
    op("R6 enable both raises summary", 0, 0, 8'h00, 1, 0, 8'hFF);
    chk("R10 read shows summary bit", {7'd0, rdata[7]}, 8'h01);
    op("R8 event wins over clear", 1, 1, 8'h40, 0, 1, 8'h00);
    op("R4 clear all", 0, 0, 8'h00, 0, 1, 8'h00);
    op("R6 disable all", 0, 0, 8'h00, 1, 0, 8'h00);

    for (int d = 0; d < 256; d++) begin
      op("R5 prep control", d[0], 1, {1'b0, d[1], 6'd0}, 1, 0, ~d[7:0]);
      op("R4 clear sweep", 0, 0, 8'h00, 0, 1, d[7:0]);
      op("R7 R5 control sweep", d[2], d[3], 8'h40, 1, 0, d[7:0]);
    end

    op("R4 clear all again", 0, 0, 8'h00, 0, 1, 8'h00);
    op("R6 disable again", 0, 0, 8'h00, 1, 0, 8'h00);
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        @(negedge clk);
        sec_mask = {4'd0, m[3:0]};
        sec_state = {s[3:0], 4'd0} | {4'd0, s[3:0]};
        #1;
        chk("R9 secondary group", {7'd0, irq}, {7'd0, (m[3:0] & s[3:0]) != 0});
      end
    end
    sec_mask = '0; sec_state = '1;
    op("R9 summary alone drives irq", 1, 0, 8'h00, 1, 0, 8'h04);
    #1;
    chk("R9 irq from summary", {7'd0, irq}, 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule